// File: doc/BRIEF.md
# Multi-Function ALU with Condition Flags

This block is a purely combinational arithmetic logic unit of parameterizable width. A 3-bit function code chooses one of three datapaths. The first is an adder/subtractor. The second is a bitwise Boolean unit offering AND, OR, XOR and NOR. The third is a barrel shifter that shifts left logically, right logically, or right arithmetically by a shift-amount input. The chosen value drives the result port.

Four condition flags come with every result. The zero and negative flags always describe the final selected result. The carry and overflow flags describe only the adder/subtractor, and they are held low for every other function. A caller can compare two operands by issuing a subtraction and reading the flags. The carry path can be built as a ripple chain or as a parallel-prefix network, and a parameter picks which one.

Top module: `alu_flags_top`

## Requirements
- R1: With function code 000 the result is (A + B) mod 2^WIDTH, and the carry flag equals the carry out of the most significant bit.
- R2: With function code 001 the result is (A - B) mod 2^WIDTH, computed as A + ~B + 1. The carry flag is 1 exactly when A >= B as unsigned numbers, meaning no borrow.
- R3: For code 000 the overflow flag is 1 exactly when A and B share a sign bit and the result's sign bit differs from it. For code 001 it is 1 exactly when the sign bits of A and B differ and the result's sign bit differs from A's.
- R4: The Boolean codes act bit by bit: 010 gives A AND B, 011 gives A OR B, 100 gives A XOR B, and 101 gives NOT (A OR B). For example, with A = 10101110 and B = 00001111 they give 00001110, 10101111, 10100001 and 01010000.
- R5: Function code 110 shifts A by the shift amount, and the 2-bit shift kind decides how. Kind 00 is a logical left shift with zero fill. Kind 01 is a logical right shift with zero fill. Kind 10 is an arithmetic right shift that fills with A's sign bit, so 11101100 shifted by 1 gives 11110110. Kind 11 passes A unchanged.
- R6: The shift amount is clog2(WIDTH) bits wide. An amount of 0 returns A unchanged for every shift kind.
- R7: The zero flag is 1 exactly when the selected result is all zeros. The negative flag equals the result's most significant bit. Both hold for every function code.
- R8: For every function code other than 000 and 001, the carry and overflow flags are 0.
- R9: Function code 111 produces an all-zero result, so the zero flag is 1.
- R10: The ripple build (ADDER_KIND 0) and the parallel-prefix build (ADDER_KIND 1) produce the same result and flags for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand; it is also the value that is shifted |
| b_i | input | WIDTH | Second operand |
| func_i | input | 3 | Function code (see R1 to R9) |
| shift_kind_i | input | 2 | Shift kind, used only with function code 110 |
| shamt_i | input | clog2(WIDTH) | Shift amount |
| result_o | output | WIDTH | Selected result |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Most significant bit of the result |
| carry_o | output | 1 | Carry out of the adder/subtractor, 0 otherwise |
| ovf_o | output | 1 | Signed overflow of the adder/subtractor, 0 otherwise |

## Verification
Several flags and results are formed in the same evaluation, and some inputs make more than one of them fire at once. A subtraction of equal operands sets zero and carry together. Adding 0xFF and 0x01 gives a zero result with carry set. Subtracting 0x01 from 0x80 sets overflow, while the negative flag reads the wrapped sign. These operand pairs are applied on purpose, alongside seeded random operands. Every flag is judged against a reference model in the bench. Both adder builds are instantiated and checked on the same vectors.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  typedef enum logic [2:0] {
    FN_ADD   = 3'b000,
    FN_SUB   = 3'b001,
    FN_AND   = 3'b010,
    FN_OR    = 3'b011,
    FN_XOR   = 3'b100,
    FN_NOR   = 3'b101,
    FN_SHIFT = 3'b110,
    FN_IDLE  = 3'b111
  } alu_fn_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'b00,
    SH_RIGHT = 2'b01,
    SH_ARITH = 2'b10,
    SH_PASS  = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    BL_AND = 2'b00,
    BL_OR  = 2'b01,
    BL_XOR = 2'b10,
    BL_NOR = 2'b11
  } bool_op_e;

  localparam int ADDER_RIPPLE = 0;
  localparam int ADDER_PREFIX = 1;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_flags_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter int ADDER_KIND = ADDER_PREFIX
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   cy;   // cy[i] is the carry into bit i

  assign b_eff = b_i ^ {WIDTH{sub_i}};

  generate
    if (ADDER_KIND == ADDER_RIPPLE) begin : g_ripple
      assign cy[0] = sub_i;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign cy[i+1] = (a_i[i] & b_eff[i]) | (cy[i] & (a_i[i] ^ b_eff[i]));
      end
    end else begin : g_prefix
      localparam int NPOS = WIDTH + 1;
      localparam int LVLS = $clog2(NPOS);
      logic [LVLS:0][NPOS-1:0] gen_t;
      logic [LVLS:0][NPOS-1:0] prp_t;
      logic                    prefix_unused;

      // position 0 carries the carry-in, positions 1..WIDTH the operand bits
      assign gen_t[0][0] = sub_i;
      assign prp_t[0][0] = 1'b0;
      for (genvar i = 0; i < WIDTH; i++) begin : g_seed
        assign gen_t[0][i+1] = a_i[i] & b_eff[i];
        assign prp_t[0][i+1] = a_i[i] ^ b_eff[i];
      end

      for (genvar k = 1; k <= LVLS; k++) begin : g_lvl
        localparam int DIST = 1 << (k - 1);
        for (genvar j = 0; j < NPOS; j++) begin : g_pos
          if (j >= DIST) begin : g_merge
            assign gen_t[k][j] = gen_t[k-1][j] | (prp_t[k-1][j] & gen_t[k-1][j-DIST]);
            assign prp_t[k][j] = prp_t[k-1][j] & prp_t[k-1][j-DIST];
          end else begin : g_copy
            assign gen_t[k][j] = gen_t[k-1][j];
            assign prp_t[k][j] = prp_t[k-1][j];
          end
        end
      end

      assign cy            = gen_t[LVLS];
      assign prefix_unused = ^prp_t;
    end
  endgenerate

  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    assign sum_o[i] = a_i[i] ^ b_eff[i] ^ cy[i];
  end

  assign carry_o = cy[WIDTH];
  assign ovf_o   = cy[WIDTH] ^ cy[WIDTH-1];

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_flags_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  bool_op_e         op_i,
  output logic [WIDTH-1:0] y_o
);

  // identical slice per bit, no signal crosses between slices
  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic f_and, f_or, f_xor, f_nor;
    assign f_and = a_i[i] & b_i[i];
    assign f_or  = a_i[i] | b_i[i];
    assign f_xor = a_i[i] ^ b_i[i];
    assign f_nor = ~f_or;
    always_comb begin
      unique case (op_i)
        BL_AND:  y_o[i] = f_and;
        BL_OR:   y_o[i] = f_or;
        BL_XOR:  y_o[i] = f_xor;
        default: y_o[i] = f_nor;
      endcase
    end
  end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_flags_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [SHW-1:0]   shamt_i,
  input  shift_kind_e      kind_i,
  output logic [WIDTH-1:0] y_o
);

  logic                     go_left;
  logic                     fill;
  logic [WIDTH-1:0]         a_rev;
  logic [SHW:0][WIDTH-1:0]  stage;
  logic [WIDTH-1:0]         out_rev;

  assign go_left = (kind_i == SH_LEFT);
  assign fill    = (kind_i == SH_ARITH) & a_i[WIDTH-1];

  always_comb begin
    for (int i = 0; i < WIDTH; i++) a_rev[i] = a_i[WIDTH-1-i];
  end

  // one right-shifting stage per amount bit; left shifts run mirrored
  assign stage[0] = go_left ? a_rev : a_i;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int DIST = 1 << s;
    assign stage[s+1] = shamt_i[s]
      ? {{DIST{fill}}, stage[s][WIDTH-1:DIST]}
      : stage[s];
  end

  always_comb begin
    for (int i = 0; i < WIDTH; i++) out_rev[i] = stage[SHW][WIDTH-1-i];
  end

  always_comb begin
    unique case (kind_i)
      SH_LEFT:  y_o = out_rev;
      SH_PASS:  y_o = a_i;
      default:  y_o = stage[SHW];
    endcase
  end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] res_i,
  input  logic             arith_i,
  input  logic             carry_i,
  input  logic             ovf_i,
  output logic             zero_o,
  output logic             neg_o,
  output logic             carry_o,
  output logic             ovf_o
);

  assign zero_o  = ~|res_i;
  assign neg_o   = res_i[WIDTH-1];
  assign carry_o = arith_i & carry_i;
  assign ovf_o   = arith_i & ovf_i;

endmodule

// File: rtl/alu_flags_top.sv
module alu_flags_top
  import alu_flags_pkg::*;
#(
  parameter int  WIDTH      = 16,
  parameter int  ADDER_KIND = ADDER_PREFIX,
  localparam int SHW        = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       func_i,
  input  logic [1:0]       shift_kind_i,
  input  logic [SHW-1:0]   shamt_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             neg_o,
  output logic             carry_o,
  output logic             ovf_o
);

  alu_fn_e          fn;
  logic             is_arith;
  bool_op_e         bool_op;
  logic [WIDTH-1:0] sum_w, bool_w, shift_w;
  logic             carry_w, ovf_w;

  assign fn       = alu_fn_e'(func_i);
  assign is_arith = (fn == FN_ADD) || (fn == FN_SUB);
  // codes 010..101 map onto Boolean selects 00..11
  assign bool_op  = bool_op_e'(func_i[1:0] - 2'd2);

  alu_addsub #(.WIDTH(WIDTH), .ADDER_KIND(ADDER_KIND)) u_addsub (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (fn == FN_SUB),
    .sum_o   (sum_w),
    .carry_o (carry_w),
    .ovf_o   (ovf_w)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .op_i (bool_op),
    .y_o  (bool_w)
  );

  alu_shift #(.WIDTH(WIDTH)) u_shift (
    .a_i     (a_i),
    .shamt_i (shamt_i),
    .kind_i  (shift_kind_e'(shift_kind_i)),
    .y_o     (shift_w)
  );

  always_comb begin
    unique case (fn)
      FN_ADD, FN_SUB:                 result_o = sum_w;
      FN_AND, FN_OR, FN_XOR, FN_NOR:  result_o = bool_w;
      FN_SHIFT:                       result_o = shift_w;
      default:                        result_o = '0;
    endcase
  end

  alu_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .res_i   (result_o),
    .arith_i (is_arith),
    .carry_i (carry_w),
    .ovf_i   (ovf_w),
    .zero_o  (zero_o),
    .neg_o   (neg_o),
    .carry_o (carry_o),
    .ovf_o   (ovf_o)
  );

endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
  parameter int  WIDTH = 16,
  localparam int SHW   = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       func_i,
  input logic [1:0]       shift_kind_i,
  input logic [SHW-1:0]   shamt_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             neg_o,
  input logic             carry_o,
  input logic             ovf_o
);

  logic known;
  logic sa, sb, sr;

  assign known = !$isunknown({a_i, b_i, func_i, shift_kind_i, shamt_i});
  assign sa = a_i[WIDTH-1];
  assign sb = b_i[WIDTH-1];
  assign sr = result_o[WIDTH-1];

  always_comb begin
    if (known) begin
      p_zero_flag_r7: assert (zero_o == (result_o == '0))
        else $error("zero flag disagrees with result");
      p_neg_flag_r7: assert (neg_o == sr)
        else $error("negative flag disagrees with result");
      p_quiet_flags_r8: assert (func_i[2:1] == 2'b00 || (!carry_o && !ovf_o))
        else $error("carry/overflow set outside arithmetic");
      p_add_overflow_r3: assert (func_i != 3'b000 || ovf_o == ((sa == sb) && (sr != sa)))
        else $error("add overflow mismatch");
      p_sub_overflow_r3: assert (func_i != 3'b001 || ovf_o == ((sa != sb) && (sr != sa)))
        else $error("sub overflow mismatch");
      p_and_bits_r4: assert (func_i != 3'b010 || result_o == (a_i & b_i))
        else $error("AND result mismatch");
      p_nor_bits_r4: assert (func_i != 3'b101 || result_o == ~(a_i | b_i))
        else $error("NOR result mismatch");
      p_shift_none_r6: assert (func_i != 3'b110 || shamt_i != '0 || result_o == a_i)
        else $error("zero shift altered operand");
      p_shift_pass_r5: assert (func_i != 3'b110 || shift_kind_i != 2'b11 || result_o == a_i)
        else $error("pass kind altered operand");
      p_idle_code_r9: assert (func_i != 3'b111 || result_o == '0)
        else $error("idle code gave non-zero result");
    end
  end

endmodule

bind alu_flags_top alu_flags_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i          (a_i),
  .b_i          (b_i),
  .func_i       (func_i),
  .shift_kind_i (shift_kind_i),
  .shamt_i      (shamt_i),
  .result_o     (result_o),
  .zero_o       (zero_o),
  .neg_o        (neg_o),
  .carry_o      (carry_o),
  .ovf_o        (ovf_o)
);

// File: tb/test_alu_flags_top.sv
`timescale 1ns/1ps
module test_alu_flags_top;

  localparam int W   = 8;
  localparam int SHW = $clog2(W);
  localparam int WATCH_NS = 400000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [W-1:0]   a, b;
  logic [2:0]     fn;
  logic [1:0]     kind;
  logic [SHW-1:0] sh;

  logic [W-1:0] res_p, res_r;
  logic z_p, n_p, c_p, v_p, z_r, n_r, c_r, v_r;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  alu_flags_top #(.WIDTH(W), .ADDER_KIND(1)) i_alu_flags_top (
    .a_i(a), .b_i(b), .func_i(fn), .shift_kind_i(kind), .shamt_i(sh),
    .result_o(res_p), .zero_o(z_p), .neg_o(n_p), .carry_o(c_p), .ovf_o(v_p)
  );

  alu_flags_top #(.WIDTH(W), .ADDER_KIND(0)) i_alu_flags_top_ripple (
    .a_i(a), .b_i(b), .func_i(fn), .shift_kind_i(kind), .shamt_i(sh),
    .result_o(res_r), .zero_o(z_r), .neg_o(n_r), .carry_o(c_r), .ovf_o(v_r)
  );

  // reference model: {result, zero, neg, carry, ovf}
  function automatic logic [W+3:0] ref_alu(logic [W-1:0] ra, logic [W-1:0] rb,
                                           logic [2:0] rf, logic [1:0] rk,
                                           logic [SHW-1:0] rs);
    logic [W:0]   t;
    logic [W-1:0] r;
    logic         c, v;
    c = 1'b0; v = 1'b0; t = '0;
    case (rf)
      3'b000: begin
        t = {1'b0, ra} + {1'b0, rb}; r = t[W-1:0]; c = t[W];
        v = (ra[W-1] == rb[W-1]) && (r[W-1] != ra[W-1]);
      end
      3'b001: begin
        r = ra - rb; c = (ra >= rb);
        v = (ra[W-1] != rb[W-1]) && (r[W-1] != ra[W-1]);
      end
      3'b010: r = ra & rb;
      3'b011: r = ra | rb;
      3'b100: r = ra ^ rb;
      3'b101: r = ~(ra | rb);
      3'b110: case (rk)
        2'b00:   r = ra << rs;
        2'b01:   r = ra >> rs;
        2'b10:   r = W'($signed(ra) >>> rs);
        default: r = ra;
      endcase
      default: r = '0;
    endcase
    return {r, (r == '0), r[W-1], c, v};
  endfunction

  task automatic check(string tag, string what, logic [W-1:0] got, logic [W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic run_vec(logic [W-1:0] va, logic [W-1:0] vb, logic [2:0] vf,
                         logic [1:0] vk, logic [SHW-1:0] vs);
    logic [W+3:0] e;
    string tr, tf;
    @(posedge clk);
    #1;
    a = va; b = vb; fn = vf; kind = vk; sh = vs;
    @(negedge clk);
    e = ref_alu(va, vb, vf, vk, vs);
    case (vf)
      3'b000:  tr = "R1";
      3'b001:  tr = "R2";
      3'b110:  tr = (vs == '0) ? "R6" : "R5";
      3'b111:  tr = "R9";
      default: tr = "R4";
    endcase
    tf = (vf[2:1] == 2'b00) ? "R3" : "R8";
    check(tr,   "result",    res_p, e[W+3:4]);
    check("R7", "zero/neg",  W'({z_p, n_p}), W'(e[3:2]));
    check(tf,   "carry/ovf", W'({c_p, v_p}), W'(e[1:0]));
    check("R10", "ripple build", {res_r[W-3:0], z_r, n_r}, {res_p[W-3:0], z_p, n_p});
    check("R10", "ripple flags", W'({res_r[W-1:W-2], c_r, v_r}), W'(e[W+3:W+2]) << 2 | W'(e[1:0]));
  endtask

  initial begin
    a = '0; b = '0; fn = '0; kind = '0; sh = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // reset state: idle inputs give an all-zero sum with zero flag set
    check("R1", "reset result", res_p, '0);
    check("R7", "reset zero",   W'(z_p), W'(1));
    rst = 1'b0;

    // Boolean examples (R4)
    run_vec(8'hAE, 8'h0F, 3'b010, 2'b00, 3'd0);
    check("R4", "AND literal", res_p, 8'h0E);
    run_vec(8'hAE, 8'h0F, 3'b011, 2'b00, 3'd0);
    check("R4", "OR literal", res_p, 8'hAF);
    run_vec(8'hAE, 8'h0F, 3'b100, 2'b00, 3'd0);
    check("R4", "XOR literal", res_p, 8'hA1);
    run_vec(8'hAE, 8'h0F, 3'b101, 2'b00, 3'd0);
    check("R4", "NOR literal", res_p, 8'h50);
    // shift examples (R5)
    run_vec(8'h14, 8'h00, 3'b110, 2'b00, 3'd1);
    check("R5", "SLL literal", res_p, 8'h28);
    run_vec(8'h14, 8'h00, 3'b110, 2'b01, 3'd1);
    check("R5", "SRL literal", res_p, 8'h0A);
    run_vec(8'hEC, 8'h00, 3'b110, 2'b10, 3'd1);
    check("R5", "SRA literal", res_p, 8'hF6);
    run_vec(8'hEC, 8'h00, 3'b110, 2'b11, 3'd5);
    check("R5", "pass kind", res_p, 8'hEC);
    for (int k = 0; k < 4; k++) run_vec(8'h9B, 8'h33, 3'b110, 2'(k), 3'd0);  // R6
    run_vec(8'h80, 8'h00, 3'b110, 2'b10, 3'd7);
    check("R5", "SRA full", res_p, 8'hFF);
    // arithmetic corners where several flags rise together (R1 R2 R3)
    run_vec(8'h7F, 8'h01, 3'b000, 2'b00, 3'd0);
    check("R3", "add ovf", W'(v_p), W'(1));
    run_vec(8'hFF, 8'h01, 3'b000, 2'b00, 3'd0);
    check("R1", "add wrap carry", W'({c_p, z_p}), W'(2'b11));
    run_vec(8'h80, 8'h01, 3'b001, 2'b00, 3'd0);
    check("R3", "sub ovf", W'({v_p, n_p}), W'(2'b10));
    run_vec(8'h5A, 8'h5A, 3'b001, 2'b00, 3'd0);
    check("R2", "sub equal", W'({c_p, z_p}), W'(2'b11));
    run_vec(8'h00, 8'h01, 3'b001, 2'b00, 3'd0);
    check("R2", "sub borrow", W'(c_p), W'(0));
    // idle code and non-arithmetic flags (R9 R8)
    run_vec(8'hFF, 8'hFF, 3'b111, 2'b00, 3'd3);
    check("R9", "idle", res_p, 8'h00);
    run_vec(8'hFF, 8'h01, 3'b011, 2'b00, 3'd0);
    check("R8", "or flags", W'({c_p, v_p}), W'(0));

    void'($urandom(32'd20110323));
    for (int i = 0; i < 1500; i++) begin
      run_vec(W'($urandom), W'($urandom), 3'($urandom), 2'($urandom), SHW'($urandom));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(WATCH_NS);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule